// File: doc/BRIEF.md
# Iterative Fraction Divider with Sticky Flag

This block divides one unsigned 64-bit fraction by another, one quotient bit per clock, using a compare-and-subtract step. A caller presents the dividend, a normalized divisor (top bit set) and a step budget, then pulses `start`. The divider iterates until the step budget runs out or the partial remainder reaches zero, whichever comes first. It then left-justifies the quotient so that the first computed bit lands in bit 63, and reports whether any remainder was left over as a sticky flag for later rounding.

Because the loop stops as soon as the remainder is exhausted, exact divisions finish in fewer cycles than inexact ones. The final alignment shift accounts for the number of steps that actually ran. The internal remainder is one bit wider than the operands, so the bit shifted out of the top after a step is never lost. Zero divisors and special operands are the caller's concern.

Top module: `frac_div`

## Requirements
- R1: After reset, `busy`, `done` and `sticky` are 0 and `quotient` is all zeros.
- R2: `start` is accepted only while `busy` is 0; a `start` raised while `busy` is 1 has no effect on the running division, its result or its latency.
- R3: From the cycle after an accepted `start`, `busy` stays 1 until the result appears; `done` is then 1 for exactly one cycle, with `busy` 0 in that cycle.
- R4: Each step shifts the quotient left by one; if the partial remainder is greater than or equal to the divisor, the divisor is subtracted and the new quotient LSB is 1, otherwise 0; the remainder is then shifted left by one, held on 65 bits.
- R5: Steps continue only while the step count is below the precision limit and the remainder is nonzero; `done` rises exactly steps+1 clock edges after the edge that accepted `start`.
- R6: The reported quotient is the step quotient shifted left by 64 minus the number of steps run, so its first computed bit sits in bit 63.
- R7: `sticky` is 1 when the remainder left after the last step is nonzero, and 0 otherwise.
- R8: A precision of 64 runs up to 64 steps; a precision value above 64 behaves as 64.
- R9: A zero dividend completes after one cycle with an all-zero quotient and `sticky` 0, whatever the precision.
- R10: A precision of 0 runs no steps: the quotient is zero, `sticky` equals whether the dividend is nonzero, and `done` comes one edge after `start`.
- R11: `quotient` and `sticky` keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (sampled only when idle) |
| dividend | input | 64 | Dividend fraction |
| divisor | input | 64 | Divisor fraction, bit 63 expected set |
| precision | input | 7 | Maximum number of quotient steps, 0 to 127 (values above 64 act as 64) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | 64 | Left-justified quotient |
| sticky | output | 1 | Nonzero leftover remainder |

## Verification
The hard case to reach from the ports is early termination after a middling number of steps: random 64-bit operands almost never leave an exact zero remainder, so they nearly always run to the precision limit. The stimulus builds operands whose low bits are zero in both dividend and divisor, with only a short random field at the top, which makes the remainder vanish after a handful of steps and exercises the realignment shift at many different step counts. Directed cases add equal operands, a half-size dividend, zero dividends, zero and oversized precision, and a second `start` issued mid-run.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int FRAC_W = 64;
  localparam int PREC_W = $clog2(FRAC_W) + 1;

  typedef struct packed {
    logic              load;
    logic              step;
    logic              finish;
    logic [PREC_W-1:0] stepCount;
  } divCtrl_t;
endpackage

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int FW = FRAC_W,
  parameter int PW = PREC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [PW-1:0] precision,
  input  logic          remZero,
  output divCtrl_t      ctrl,
  output logic          busy,
  output logic          done
);
  typedef enum logic {IDLE, RUN} state_t;

  localparam logic [PW-1:0] MAX_STEPS = PW'(FW);

  state_t        state;
  logic [PW-1:0] stepCnt;
  logic [PW-1:0] limit;
  logic          goOn;

  assign goOn = (stepCnt < limit) && !remZero;

  always_comb begin
    ctrl.load      = (state == IDLE) && start;
    ctrl.step      = (state == RUN) && goOn;
    ctrl.finish    = (state == RUN) && !goOn;
    ctrl.stepCount = stepCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      stepCnt <= '0;
      limit   <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.load) begin
        state   <= RUN;
        stepCnt <= '0;
        limit   <= (precision > MAX_STEPS) ? MAX_STEPS : precision;
      end else if (ctrl.step) begin
        stepCnt <= stepCnt + 1'b1;
      end else if (ctrl.finish) begin
        state <= IDLE;
      end
    end
  end

  assign busy = (state == RUN);
endmodule

// File: rtl/frac_div_dp.sv
module frac_div_dp
  import frac_div_pkg::*;
#(
  parameter int FW = FRAC_W,
  parameter int PW = PREC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  divCtrl_t      ctrl,
  input  logic [FW-1:0] dividend,
  input  logic [FW-1:0] divisor,
  output logic          remZero,
  output logic [FW-1:0] quotient,
  output logic          sticky
);
  localparam int RW = FW + 1;

  logic [RW-1:0] rem;
  logic [FW-1:0] dvsr;
  logic [FW-1:0] quoAcc;
  logic [RW-1:0] dvsrWide;
  logic          fits;
  logic [RW-1:0] remAfter;
  logic [PW-1:0] alignShift;

  assign dvsrWide   = {1'b0, dvsr};
  assign fits       = (rem >= dvsrWide);
  assign remAfter   = fits ? (rem - dvsrWide) : rem;
  assign remZero    = (rem == '0);
  assign alignShift = PW'(FW) - ctrl.stepCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem      <= '0;
      dvsr     <= '0;
      quoAcc   <= '0;
      quotient <= '0;
      sticky   <= 1'b0;
    end else begin
      if (ctrl.load) begin
        rem    <= {1'b0, dividend};
        dvsr   <= divisor;
        quoAcc <= '0;
      end else if (ctrl.step) begin
        rem    <= {remAfter[RW-2:0], 1'b0};
        quoAcc <= {quoAcc[FW-2:0], fits};
      end
      if (ctrl.finish) begin
        quotient <= quoAcc << alignShift;
        sticky   <= !remZero;
      end
    end
  end
endmodule

// File: rtl/frac_div.sv
module frac_div
  import frac_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FRAC_W-1:0] dividend,
  input  logic [FRAC_W-1:0] divisor,
  input  logic [PREC_W-1:0] precision,
  output logic              busy,
  output logic              done,
  output logic [FRAC_W-1:0] quotient,
  output logic              sticky
);
  divCtrl_t ctrl;
  logic     remZero;

  frac_div_ctrl #(.FW(FRAC_W), .PW(PREC_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .precision (precision),
    .remZero   (remZero),
    .ctrl      (ctrl),
    .busy      (busy),
    .done      (done)
  );

  frac_div_dp #(.FW(FRAC_W), .PW(PREC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dividend (dividend),
    .divisor  (divisor),
    .remZero  (remZero),
    .quotient (quotient),
    .sticky   (sticky)
  );
endmodule

// File: rtl/frac_div_check.sv
module frac_div_check
  import frac_div_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [FRAC_W-1:0] dividend,
  input logic [FRAC_W-1:0] divisor,
  input logic [PREC_W-1:0] precision,
  input logic              busy,
  input logic              done,
  input logic [FRAC_W-1:0] quotient,
  input logic              sticky
);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || ($stable(quotient) && $stable(sticky))));

  p_zero_dividend_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && dividend == '0) |=> ##1 (done && quotient == '0 && !sticky));

  p_no_steps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && precision == '0) |=> ##1 (done && quotient == '0));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));
endmodule

bind frac_div frac_div_check u_chk (.*);

// File: tb/frac_div_bench.sv
module frac_div_bench;
  localparam int FW = 64;
  localparam int PW = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] dividend = '0;
  logic [FW-1:0] divisor = '0;
  logic [PW-1:0] precision = '0;
  logic          busy;
  logic          done;
  logic [FW-1:0] quotient;
  logic          sticky;

  int total = 0;
  int bad = 0;
  bit hung = 0;

  always #4 clk = ~clk;

  frac_div u_frac_div (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .precision(precision), .busy(busy), .done(done),
    .quotient(quotient), .sticky(sticky)
  );

  task automatic check64(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: compare-and-subtract on a 65-bit remainder (R4..R8)
  function automatic void model(input logic [FW-1:0] dvd, input logic [FW-1:0] dvr,
                                input int prec, output logic [FW-1:0] quo,
                                output logic st, output int steps);
    logic [FW:0] r;
    logic [FW-1:0] q;
    int lim;
    r = {1'b0, dvd};
    q = '0;
    lim = (prec > FW) ? FW : prec;
    steps = 0;
    while (steps < lim && r != '0) begin
      q = q << 1;
      if (r >= {1'b0, dvr}) begin
        r = r - {1'b0, dvr};
        q[0] = 1'b1;
      end
      r = r << 1;
      steps++;
    end
    quo = (steps == 0) ? '0 : (q << (FW - steps));
    st = (r != '0);
  endfunction

  // Runs one division; optional intruding start while busy (R2)
  task automatic run_div(input logic [FW-1:0] dvd, input logic [FW-1:0] dvr,
                         input int prec, input bit intrude, input string tag);
    logic [FW-1:0] eq;
    logic est;
    int esteps;
    int lat;
    bit busyOk;
    model(dvd, dvr, prec, eq, est, esteps);
    @(negedge clk);
    start = 1'b1; dividend = dvd; divisor = dvr; precision = PW'(prec);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busyOk = 1;
    while (!done) begin
      if (!busy) busyOk = 0;
      if (intrude && lat == 0 && busy) begin
        start = 1'b1; dividend = ~dvd; divisor = dvr ^ 64'h0F0F; precision = 7'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
      if (lat > 200) begin
        hung = 1;
        break;
      end
    end
    start = 1'b0;
    check64({tag, " R3 busy"}, {63'b0, busyOk && !busy}, 64'd1);
    check64({tag, " R4 R6 quotient"}, quotient, eq);
    check64({tag, " R7 sticky"}, {63'b0, sticky}, {63'b0, est});
    check64({tag, " R5 latency"}, 64'(lat), 64'(esteps + 1));
    if (intrude) check64({tag, " R2 ignored start"}, quotient, eq);
    @(negedge clk);
    check64({tag, " R3 pulse"}, {63'b0, done}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    hung = 1;
  end

  initial begin
    logic [FW-1:0] a, b, hq;
    logic hs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check64("R1 reset busy", {63'b0, busy}, 64'd0);
    check64("R1 reset done", {63'b0, done}, 64'd0);
    check64("R1 reset quotient", quotient, '0);
    check64("R1 reset sticky", {63'b0, sticky}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    run_div(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64, 0, "equal");
    run_div(64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000, 64, 0, "half");
    run_div(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64, 0, "R8 full");
    run_div(64'h5555_5555_5555_5555, 64'hC000_0000_0000_0000, 100, 0, "R8 over");
    run_div(64'h5555_5555_5555_5555, 64'hC000_0000_0000_0000, 64, 0, "R8 at64");
    run_div('0, 64'h9000_0000_0000_0000, 64, 0, "R9 zero");
    run_div('0, 64'hF000_0000_0000_0000, 0, 0, "R9 zero p0");
    run_div(64'h1234, 64'h8000_0000_0000_0000, 0, 0, "R10 p0");
    run_div(64'hAAAA_0000_0000_0000, 64'hB000_0000_0000_0000, 5, 0, "short");
    run_div(64'h7777_7777_7777_7777, 64'hE000_0000_0000_0003, 40, 1, "R2 intrude");

    // R11: result held after done until next division
    hq = quotient; hs = sticky;
    repeat (5) @(negedge clk);
    check64("R11 hold quotient", quotient, hq);
    check64("R11 hold sticky", {63'b0, sticky}, {63'b0, hs});

    for (int i = 0; i < 150 && !hung; i++) begin
      int p;
      int kind;
      kind = $urandom_range(0, 2);
      p = (i % 10 == 0) ? $urandom_range(65, 127) : $urandom_range(0, 64);
      if (kind == 0) begin
        a = {$urandom, $urandom};
        b = {1'b1, 31'($urandom), $urandom};
      end else begin
        // short fields at the top: remainder tends to vanish early (R5)
        a = {16'($urandom), 48'b0} >> $urandom_range(0, 3);
        b = {1'b1, 7'($urandom), 56'b0};
      end
      run_div(a, b, p, (i % 17 == 3), "random");
    end

    if (hung) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule